// File: doc/BRIEF.md
# Reset-Gated Memory Access Guard

This block sits between a serial-bus slave front end and the write engine of a nonvolatile memory. Its input is the reset line of a supply supervisor. It uses that line to protect stored data. When supervisor reset goes active, the guard does three things:

- It kills whatever bus transaction the front end is handling.
- It turns away any new start condition.
- It refuses to launch an internal write cycle.

A write cycle that has already been launched is different. It cannot be stopped partway, so the guard lets it run its full length and keeps the busy flag high the whole time.

The front end reports bus start and stop conditions as single-cycle strobes. The guard tracks whether an accepted transaction is open and whether memory access is currently allowed. The abort output gives a one-cycle kill strobe on the rising edge of supervisor reset. The hold output keeps the front end idle for as long as reset stays active.

Write launches use a valid/ready handshake. The requester raises `wr_req_valid_i` and keeps it high until it sees `wr_req_ready_o` high in the same cycle; the launch happens in that cycle. Ready is low whenever supervisor reset is active or a write cycle is running, which is the back-pressure. Ready depends on `sup_rst_i` without a register in between. As a result, reset wins over a request that arrives in the same cycle.

Top module: `mem_reset_guard`

## Requirements
- R1: `fe_abort_o` is high only in the first cycle in which `sup_rst_i` is high after being low (or after system reset), and low in every other cycle.
- R2: `fe_hold_o` is high in exactly the cycles in which `sup_rst_i` is high.
- R3: A transaction open when `sup_rst_i` rises is closed: `txn_active_o` is low from the next cycle on.
- R4: A bus start strobe while `sup_rst_i` is high gives no `txn_grant_o` and leaves `txn_active_o` low.
- R5: A start strobe while `sup_rst_i` is low raises `txn_grant_o` in the same cycle and `txn_active_o` from the next cycle.
- R6: After `sup_rst_i` falls, the aborted transaction is not resumed: `txn_active_o` stays low until a fresh start strobe.
- R7: `wr_req_ready_o` is low in every cycle with `sup_rst_i` high, including the cycle it first rises. A request in such a cycle launches nothing: `wr_go_o` stays low and `wr_busy_o` stays low.
- R8: A handshake (valid and ready both high) raises `wr_go_o` in that cycle. `wr_busy_o` is then high for exactly `WR_CYCLES` cycles starting the next cycle.
- R9: Raising `sup_rst_i` during a write cycle does not shorten it; `wr_busy_o` still lasts `WR_CYCLES` cycles.
- R10: While `wr_busy_o` is high, `wr_req_ready_o` is low and requests are ignored.
- R11: A bus stop strobe closes the open transaction: `txn_active_o` is low from the next cycle.
- R12: `mem_en_o` is high only when a transaction is open and `sup_rst_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| sup_rst_i | input | 1 | Supervisor reset, high = active |
| bus_start_i | input | 1 | Bus start condition strobe from front end |
| bus_stop_i | input | 1 | Bus stop condition strobe from front end |
| fe_abort_o | output | 1 | One-cycle kill strobe to front end |
| fe_hold_o | output | 1 | Keep front end idle |
| txn_grant_o | output | 1 | Start condition accepted this cycle |
| txn_active_o | output | 1 | An accepted transaction is open |
| mem_en_o | output | 1 | Memory access currently permitted |
| wr_req_valid_i | input | 1 | Write launch request valid |
| wr_req_ready_o | output | 1 | Write launch can be accepted |
| wr_go_o | output | 1 | Launch strobe to write engine |
| wr_busy_o | output | 1 | Internal write cycle running |

## Verification
The bus side is driven through a table of start, stop and reset combinations. The table covers four patterns, each telling apart a different fault:

- An ordinary start-to-stop transaction, which separates correct tracking from a stuck state.
- Reset landing mid-transaction, which separates abort from resume.
- Start strobes inside reset, which shows whether gating of new work is present.
- A start in the same cycle that reset rises, which exposes a wrong priority.

The write side is tried three ways: with a clean launch, with reset raised partway through a running cycle, and with reset and request arriving together. Together these separate a launch that is correctly gated from one that is cut short or let through.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  typedef struct packed {
    logic start;
    logic stop;
  } bus_evt_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sup_edge_det.sv
module sup_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/bus_txn_tracker.sv
module bus_txn_tracker
  import mem_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     block_i,
  input  bus_evt_t evt_i,
  output logic     grant_o,
  output logic     open_o
);
  logic open_q;

  assign grant_o = evt_i.start & ~block_i;

  always_ff @(posedge clk) begin
    if (!rst_n)           open_q <= 1'b0;
    else if (block_i)     open_q <= 1'b0;
    else if (grant_o)     open_q <= 1'b1;
    else if (evt_i.stop)  open_q <= 1'b0;
  end

  assign open_o = open_q;
endmodule

// File: rtl/wr_cycle_timer.sv
module wr_cycle_timer
  import mem_guard_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o
);
  localparam int unsigned CW = cnt_width(WR_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (launch_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mem_reset_guard.sv
module mem_reset_guard
  import mem_guard_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst_i,
  input  logic bus_start_i,
  input  logic bus_stop_i,
  output logic fe_abort_o,
  output logic fe_hold_o,
  output logic txn_grant_o,
  output logic txn_active_o,
  output logic mem_en_o,
  input  logic wr_req_valid_i,
  output logic wr_req_ready_o,
  output logic wr_go_o,
  output logic wr_busy_o
);
  bus_evt_t evt;
  logic     busy;

  assign evt.start = bus_start_i;
  assign evt.stop  = bus_stop_i;

  sup_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sup_rst_i),
    .rise_o  (fe_abort_o)
  );

  bus_txn_tracker u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .block_i (sup_rst_i),
    .evt_i   (evt),
    .grant_o (txn_grant_o),
    .open_o  (txn_active_o)
  );

  // Reset wins over a same-cycle request: ready is combinational on sup_rst_i.
  assign wr_req_ready_o = ~sup_rst_i & ~busy;
  assign wr_go_o        = wr_req_valid_i & wr_req_ready_o;

  // The timer sees only the launch strobe, so supervisor reset cannot cut it short.
  wr_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (wr_go_o),
    .busy_o   (busy)
  );

  assign wr_busy_o = busy;
  assign fe_hold_o = sup_rst_i;
  assign mem_en_o  = txn_active_o & ~sup_rst_i;
endmodule

// File: rtl/mem_reset_guard_chk.sv
module mem_reset_guard_chk #(
  parameter int unsigned WR_CYCLES = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic sup_rst_i,
  input logic bus_start_i,
  input logic fe_abort_o,
  input logic txn_grant_o,
  input logic txn_active_o,
  input logic mem_en_o,
  input logic wr_req_valid_i,
  input logic wr_req_ready_o,
  input logic wr_go_o,
  input logic wr_busy_o
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_len <= 0;
    else if (wr_busy_o) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  // R1
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_abort_o |=> !fe_abort_o);
  // R1
  abort_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_abort_o |-> sup_rst_i);
  // R3
  txn_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst_i |=> !txn_active_o);
  // R4
  no_grant_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_rst_i && bus_start_i) |-> !txn_grant_o);
  // R6
  open_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txn_active_o) |-> $past(txn_grant_o));
  // R7
  no_launch_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst_i |-> !wr_go_o);
  // R8
  busy_from_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy_o) |-> $past(wr_go_o));
  // R9
  busy_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy_o) |-> (run_len == WR_CYCLES));
  // R10
  no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_o |-> !wr_req_ready_o);
  // R12
  mem_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_o |-> (txn_active_o && !sup_rst_i));

  logic unused_ok;
  assign unused_ok = wr_req_valid_i;
endmodule

bind mem_reset_guard mem_reset_guard_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sup_rst_i      (sup_rst_i),
  .bus_start_i    (bus_start_i),
  .fe_abort_o     (fe_abort_o),
  .txn_grant_o    (txn_grant_o),
  .txn_active_o   (txn_active_o),
  .mem_en_o       (mem_en_o),
  .wr_req_valid_i (wr_req_valid_i),
  .wr_req_ready_o (wr_req_ready_o),
  .wr_go_o        (wr_go_o),
  .wr_busy_o      (wr_busy_o)
);

// File: tb/mem_reset_guard_bench.sv
module mem_reset_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WR = 8;

  logic clk = 1'b0;
  logic rst_n, sup_rst, bstart, bstop, wvalid;
  logic abort, hold, grant, active, memen, wready, wgo, wbusy;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_reset_guard #(.WR_CYCLES(WR)) u_mem_reset_guard (
    .clk(clk), .rst_n(rst_n), .sup_rst_i(sup_rst),
    .bus_start_i(bstart), .bus_stop_i(bstop),
    .fe_abort_o(abort), .fe_hold_o(hold), .txn_grant_o(grant),
    .txn_active_o(active), .mem_en_o(memen),
    .wr_req_valid_i(wvalid), .wr_req_ready_o(wready),
    .wr_go_o(wgo), .wr_busy_o(wbusy)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // {sup_rst, start, stop, abort, hold, grant, active, mem_en}
  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    8'b000_00000, // idle
    8'b010_00100, // start granted (R5)
    8'b000_00011, // open
    8'b001_00011, // stop (R11)
    8'b000_00000, // closed
    8'b010_00100, // start
    8'b100_11010, // reset rises mid-transaction (R1 R3)
    8'b100_01000, // reset held
    8'b110_01000, // start in reset (R4)
    8'b000_00000, // not resumed (R6)
    8'b001_00000, // stray stop
    8'b010_00100, // fresh start
    8'b110_11010, // reset with start same cycle
    8'b000_00000  // closed
  };

  initial begin
    rst_n = 0; sup_rst = 0; bstart = 0; bstop = 0; wvalid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(active, 1'b0, "R3 reset state active");
    chk(wbusy,  1'b0, "R8 reset state busy");
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sup_rst, bstart, bstop} = VEC[i][7:5];
      #1;
      chk(abort,  VEC[i][4], "R1 table abort");
      chk(hold,   VEC[i][3], "R2 table hold");
      chk(grant,  VEC[i][2], "R4 R5 table grant");
      chk(active, VEC[i][1], "R6 R11 table active");
      chk(memen,  VEC[i][0], "R12 table mem_en");
    end
    @(negedge clk);
    {sup_rst, bstart, bstop} = 3'b000;

    // Clean launch (R8)
    @(negedge clk);
    wvalid = 1; #1;
    chk(wready, 1'b1, "R8 ready idle");
    chk(wgo,    1'b1, "R8 go on handshake");
    for (int k = 1; k <= WR; k++) begin
      @(negedge clk);
      if (k == 1) wvalid = 1;
      if (k == 3) sup_rst = 1;   // R9: reset during cycle
      #1;
      chk(wbusy,  1'b1, "R8 R9 busy held");
      chk(wready, 1'b0, "R10 ready low busy");
      chk(wgo,    1'b0, "R10 request ignored");
    end
    @(negedge clk); #1;
    chk(wbusy,  1'b0, "R8 busy ends after WR_CYCLES");
    chk(wready, 1'b0, "R7 ready low in reset");
    chk(wgo,    1'b0, "R7 no launch in reset");
    @(negedge clk); #1;
    chk(wbusy,  1'b0, "R7 no busy from reset request");
    sup_rst = 0; wvalid = 0;

    // Reset and request in same cycle (R7)
    @(negedge clk);
    sup_rst = 1; wvalid = 1; #1;
    chk(wready, 1'b0, "R7 same-cycle ready");
    chk(abort,  1'b1, "R1 abort on rise");
    @(negedge clk); #1;
    chk(wbusy,  1'b0, "R7 same-cycle no busy");
    chk(abort,  1'b0, "R1 abort one cycle");
    sup_rst = 0; #1;
    chk(wready, 1'b1, "R7 ready after release");
    chk(wgo,    1'b1, "R8 launch after release");
    @(negedge clk); wvalid = 0; #1;
    chk(wbusy,  1'b1, "R8 busy after launch");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule